// File: doc/BRIEF.md
# Two-Wire Pointer-Register Slave

This block is a synchronous slave for a two-wire serial bus that is compatible with I2C and SMBus. It samples the clock and data lines on a fast system clock. It recognises START, repeated START and STOP. It answers a 7-bit device address made of a fixed 4-bit prefix and three strap inputs. Through an 8-bit pointer it gives access to a small bank of 16-bit registers: a read-only temperature word, a configuration word, a low limit, a high limit and a write-only one-shot trigger. The block drives only an open-drain enable for SDA. That enable pulls the line low for acknowledge bits and for zero bits of read data.

Software selects a register by writing a pointer byte after a write address. Any further bytes in the same transfer are written into that register, high byte first. A later read transfer returns the selected register, high byte first, with no new pointer needed. The block sends single-cycle pulses to the surrounding logic: one per written register byte, one per read transfer (this one feeds the alert-clearing logic) and one per one-shot write. If either line stays low for too long during a transfer, the slave drops back to idle.

The controller is one state machine. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. On a match it moves to ST_ADDR_ACK, and otherwise, including for a high-speed master code, it moves to ST_HOLD. From ST_ADDR_ACK, a write goes to ST_PTR and then ST_PTR_ACK, and after that it loops between ST_WDATA and ST_WDATA_ACK. A read goes to ST_RDATA and then ST_RACK. A master ACK in ST_RACK returns to ST_RDATA with the other byte of the word loaded. A master NACK moves to ST_HOLD. From any state, a START leads to ST_ADDR, and a STOP or a timeout leads to ST_IDLE.

Top module: `tw_ptr_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits are 1001 followed by the strap value (strap[2] first). The strap value is sampled at every START. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R2: The first byte after an acknowledged write address is the pointer. Only its three low bits select the register (0 temperature, 1 configuration, 2 low limit, 3 high limit, 4 one-shot). The pointer keeps its value across transfers until the next write changes it.
- R3: Data bytes after the pointer are each acknowledged and written high byte first, with bits arriving MSB first. A STOP after only one data byte changes only the high byte. Each written byte of registers 1, 2 and 3 gives a one-cycle pulse on wr_stb bit 0, 1 or 2 respectively.
- R4: A read transfer returns the selected register high byte first. The temperature word is temp_in followed by four zero bits. Pointers 4 to 7 read as zero.
- R5: A master NACK on a read byte ends the transfer. The slave then leaves SDA released until the next START.
- R6: A high-speed master code (00001xxx) after START is not acknowledged. A following repeated START with a matching address is served normally.
- R7: If SCL or SDA stays low with no edge for TIMEOUT_CYC cycles during a transfer, the slave releases SDA and returns to idle.
- R8: After reset the low limit is 4B00h, the high limit is 5000h and configuration is 0000h. The low four bits of both limits always read zero, whatever is written.
- R9: Each data byte written at pointer 4 gives a one-cycle oneshot_pulse. Bytes written at pointer 0 change nothing.
- R10: Each acknowledged read address gives exactly one one-cycle rd_pulse.
- R11: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Level of the bus clock line |
| sda_in | input | 1 | Level of the bus data line |
| strap | input | 3 | Low three address bits |
| temp_in | input | 12 | Latest temperature result, two's complement |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_q | output | 16 | Configuration word |
| tlow_q | output | 16 | Low limit word |
| thigh_q | output | 16 | High limit word |
| wr_stb | output | 3 | Byte-written pulses for configuration, low, high |
| rd_pulse | output | 1 | One pulse per read transfer |
| oneshot_pulse | output | 1 | One pulse per byte written at pointer 4 |

## Verification
Pointer bytes with high bits set (F9h, FAh) show that only the low three bits select a register, and repeated reads with no new pointer show that the pointer persists. Full writes, a one-byte write and a reserved-nibble write tell a whole-word update apart from a high-byte update and from the masked limit storage. Foreign addresses, a changed strap, a master code followed by a repeated START, and a NACK followed by free-running clocks separate acknowledging from staying silent. A transfer frozen with SCL low shows the difference between a slave that is still driving and one the timeout has released.

// File: rtl/tw_pkg.sv
package tw_pkg;
    parameter int TW_BYTE_W  = 8;
    parameter int TW_WORD_W  = 16;
    parameter int TW_RSV_W   = 4;
    parameter int TW_PTR_W   = 3;
    parameter int TW_STRAP_W = 3;
    parameter logic [3:0] TW_DEV_PREFIX = 4'b1001;
    parameter logic [TW_WORD_W-1:0] TW_LOW_RST  = 16'h4B00;
    parameter logic [TW_WORD_W-1:0] TW_HIGH_RST = 16'h5000;

    // register selection codes, decoded from the pointer byte
    parameter logic [TW_PTR_W-1:0] TW_P_TEMP = 3'd0;
    parameter logic [TW_PTR_W-1:0] TW_P_CFG  = 3'd1;
    parameter logic [TW_PTR_W-1:0] TW_P_LOW  = 3'd2;
    parameter logic [TW_PTR_W-1:0] TW_P_HIGH = 3'd3;
    parameter logic [TW_PTR_W-1:0] TW_P_OS   = 3'd4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_HOLD
    } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[i]};
        end
        assign q[i] = chain[STAGES-1];
    end
endmodule

// File: rtl/tw_cond.sv
module tw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic any_edge
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // bus conditions only count while the clock line is high in both samples
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    assign any_edge  = (scl_s ^ scl_p) | (sda_s ^ sda_p);
endmodule

// File: rtl/tw_regs.sv
module tw_regs
    import tw_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_hi,
    input  logic [TW_PTR_W-1:0]           ptr,
    input  logic [TW_BYTE_W-1:0]          wr_byte,
    input  logic [TW_WORD_W-TW_RSV_W-1:0] temp_in,
    output logic [TW_WORD_W-1:0]          cfg_q,
    output logic [TW_WORD_W-1:0]          tlow_q,
    output logic [TW_WORD_W-1:0]          thigh_q,
    output logic [TW_WORD_W-1:0]          rd_word,
    output logic [2:0]                    wr_stb,
    output logic                          os_pulse
);
    localparam int HI_LSB = TW_WORD_W - TW_BYTE_W;

    logic [TW_WORD_W-1:0] lim_q [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && ptr == TW_P_CFG) begin
            if (wr_hi) cfg_q[TW_WORD_W-1:HI_LSB] <= wr_byte;
            else       cfg_q[TW_BYTE_W-1:0]      <= wr_byte;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_lim
        localparam logic [TW_WORD_W-1:0] RST_V = (g == 0) ? TW_LOW_RST : TW_HIGH_RST;
        localparam logic [TW_PTR_W-1:0]  SEL   = (g == 0) ? TW_P_LOW : TW_P_HIGH;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lim_q[g] <= RST_V;
            end else if (wr_en && ptr == SEL) begin
                if (wr_hi) lim_q[g][TW_WORD_W-1:HI_LSB] <= wr_byte;
                else       lim_q[g][TW_BYTE_W-1:0] <= {wr_byte[TW_BYTE_W-1:TW_RSV_W], {TW_RSV_W{1'b0}}};
            end
        end
    end

    assign tlow_q  = lim_q[0];
    assign thigh_q = lim_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb   <= '0;
            os_pulse <= 1'b0;
        end else begin
            wr_stb   <= {wr_en && ptr == TW_P_HIGH, wr_en && ptr == TW_P_LOW, wr_en && ptr == TW_P_CFG};
            os_pulse <= wr_en && ptr == TW_P_OS;
        end
    end

    always_comb begin
        case (ptr)
            TW_P_TEMP: rd_word = {temp_in, {TW_RSV_W{1'b0}}};
            TW_P_CFG:  rd_word = cfg_q;
            TW_P_LOW:  rd_word = tlow_q;
            TW_P_HIGH: rd_word = thigh_q;
            default:   rd_word = '0;
        endcase
    end
endmodule

// File: rtl/tw_ptr_slave.sv
module tw_ptr_slave
    import tw_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5_500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_in,
    input  logic                          sda_in,
    input  logic [TW_STRAP_W-1:0]         strap,
    input  logic [TW_WORD_W-TW_RSV_W-1:0] temp_in,
    output logic                          sda_oe,
    output logic [TW_WORD_W-1:0]          cfg_q,
    output logic [TW_WORD_W-1:0]          tlow_q,
    output logic [TW_WORD_W-1:0]          thigh_q,
    output logic [2:0]                    wr_stb,
    output logic                          rd_pulse,
    output logic                          oneshot_pulse
);
    localparam int CNT_W = $clog2(TW_BYTE_W + 1);
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam int HI_LSB = TW_WORD_W - TW_BYTE_W;

    tw_state_e state, state_n;
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, any_edge;
    logic [CNT_W-1:0]      bitcnt;
    logic [TW_BYTE_W-1:0]  shreg;
    logic [TW_STRAP_W-1:0] strap_q;
    logic [TW_PTR_W-1:0]   ptr_q;
    logic [TW_WORD_W-1:0]  tx_word, rd_word;
    logic [TO_W-1:0]       to_cnt;
    logic rw_q, hi_nxt, byte_done, addr_hit, timeout, wr_en;

    tw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s}));

    tw_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .any_edge(any_edge));

    tw_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(hi_nxt), .ptr(ptr_q),
        .wr_byte(shreg), .temp_in(temp_in), .cfg_q(cfg_q), .tlow_q(tlow_q),
        .thigh_q(thigh_q), .rd_word(rd_word), .wr_stb(wr_stb), .os_pulse(oneshot_pulse));

    assign byte_done = (bitcnt == CNT_W'(TW_BYTE_W));
    assign addr_hit  = (shreg[TW_BYTE_W-1:1] == {TW_DEV_PREFIX, strap_q});
    assign timeout   = (to_cnt == TO_W'(TIMEOUT_CYC));

    // stuck-bus watchdog: counts while a line is low and nothing moves
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                              to_cnt <= '0;
        else if (state == ST_IDLE || any_edge || (scl_s && sda_s)) to_cnt <= '0;
        else if (!timeout)                                       to_cnt <= to_cnt + TO_W'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (timeout)        state_n = ST_IDLE;
        else if (start_det) state_n = ST_ADDR;
        else if (stop_det)  state_n = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE, ST_HOLD: state_n = state;
                ST_ADDR:      if (scl_fall && byte_done) state_n = addr_hit ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK:  if (scl_fall) state_n = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && byte_done) state_n = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_n = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) state_n = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_n = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_done) state_n = ST_RACK;
                ST_RACK: begin
                    if (scl_rise && sda_s) state_n = ST_HOLD;
                    else if (scl_fall)     state_n = ST_RDATA;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // shift, count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0; shreg <= '0; strap_q <= '0; rw_q <= 1'b0;
            ptr_q <= '0; hi_nxt <= 1'b0; tx_word <= '0;
        end else if (start_det) begin
            bitcnt  <= '0;
            strap_q <= strap;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[TW_BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + CNT_W'(1);
                    end
                    if (scl_fall && byte_done) begin
                        if (state == ST_ADDR) rw_q <= shreg[0];
                        if (state == ST_PTR) begin
                            ptr_q  <= shreg[TW_PTR_W-1:0];
                            hi_nxt <= 1'b1;
                        end
                        if (state == ST_WDATA) hi_nxt <= ~hi_nxt;
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    if (rw_q) begin
                        tx_word <= rd_word;
                        shreg   <= rd_word[TW_WORD_W-1:HI_LSB];
                        hi_nxt  <= 1'b0;
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: if (scl_fall) bitcnt <= '0;
                ST_RDATA: begin
                    if (scl_rise) bitcnt <= bitcnt + CNT_W'(1);
                    if (scl_fall && !byte_done) shreg <= {shreg[TW_BYTE_W-2:0], 1'b0};
                end
                ST_RACK: if (scl_fall) begin
                    bitcnt <= '0;
                    shreg  <= hi_nxt ? tx_word[TW_WORD_W-1:HI_LSB] : tx_word[TW_BYTE_W-1:0];
                    hi_nxt <= ~hi_nxt;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~shreg[TW_BYTE_W-1];
            default:  sda_oe = 1'b0;
        endcase
        wr_en    = (state == ST_WDATA) && scl_fall && byte_done && !timeout;
        rd_pulse = (state == ST_ADDR_ACK) && scl_fall && rw_q && !timeout;
    end
endmodule

module tw_ptr_slave_chk
    import tw_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_s,
    input logic                 sda_oe,
    input logic                 rd_pulse,
    input logic                 oneshot_pulse,
    input logic [2:0]           wr_stb,
    input logic [TW_WORD_W-1:0] tlow_q,
    input logic [TW_WORD_W-1:0] thigh_q,
    input tw_state_e            state
);
    a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);
    a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);
    a_r9_os_single: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot_pulse |=> !oneshot_pulse);
    a_r3_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));
    a_r8_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tlow_q[TW_RSV_W-1:0] == '0) && (thigh_q[TW_RSV_W-1:0] == '0));
    a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
endmodule

bind tw_ptr_slave tw_ptr_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .rd_pulse(rd_pulse),
    .oneshot_pulse(oneshot_pulse), .wr_stb(wr_stb), .tlow_q(tlow_q),
    .thigh_q(thigh_q), .state(state));

// File: tb/tw_ptr_slave_bench.sv
module tw_ptr_slave_bench;
    localparam int TO = 200;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
    logic [2:0]  strap = 3'b101;
    logic [11:0] temp = 12'h190;
    logic sda_line, sda_oe, rd_pulse, oneshot_pulse;
    logic [15:0] cfg_q, tlow_q, thigh_q;
    logic [2:0]  wr_stb;

    assign sda_line = ~(m_low | sda_oe);
    always #2 clk = ~clk;

    tw_ptr_slave #(.TIMEOUT_CYC(TO)) u_tw_ptr_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .strap(strap),
        .temp_in(temp), .sda_oe(sda_oe), .cfg_q(cfg_q), .tlow_q(tlow_q),
        .thigh_q(thigh_q), .wr_stb(wr_stb), .rd_pulse(rd_pulse),
        .oneshot_pulse(oneshot_pulse));

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, os_cnt = 0, exp_rd = 0, exp_os = 0;
    int wr_cnt [3] = '{0, 0, 0};
    int exp_wr [3] = '{0, 0, 0};
    bit settled = 1'b0, done = 1'b0;
    logic [15:0] exp_cfg = 16'h0000, exp_lo = 16'h4B00, exp_hi = 16'h5000;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model: registers and pulse counts compared every clock while the bus rests
    always @(posedge clk) if (rst_n) begin
        if (rd_pulse) rd_cnt++;
        if (oneshot_pulse) os_cnt++;
        for (int k = 0; k < 3; k++) if (wr_stb[k]) wr_cnt[k]++;
    end

    always @(negedge clk) if (settled) begin
        chk(cfg_q == exp_cfg, "R3 cfg model", cfg_q, exp_cfg);
        chk(tlow_q == exp_lo, "R8 low model", tlow_q, exp_lo);
        chk(thigh_q == exp_hi, "R8 high model", thigh_q, exp_hi);
        chk(sda_oe == 1'b0, "R5 idle release", sda_oe, 0);
    end

    task automatic bus_start();
        w(8); m_low = 1'b0; w(4); scl = 1'b1; w(8); m_low = 1'b1; w(8); scl = 1'b0; w(2);
    endtask

    task automatic bus_stop();
        w(8); m_low = 1'b1; w(4); scl = 1'b1; w(8); m_low = 1'b0; w(8);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            w(6); m_low = ~b[i]; w(2); scl = 1'b1; w(8); scl = 1'b0;
        end
        w(6); m_low = 1'b0; w(2); scl = 1'b1; w(4); acked = (sda_line == 1'b0); w(4); scl = 1'b0;
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            w(8); scl = 1'b1; w(4); b[i] = sda_line; w(4); scl = 1'b0;
        end
        w(6); m_low = mack; w(2); scl = 1'b1; w(8); scl = 1'b0; w(2); m_low = 1'b0;
    endtask

    function automatic logic [7:0] adr(input logic [2:0] s, input bit rd);
        return {4'b1001, s, rd};
    endfunction

    task automatic wr_reg(input logic [2:0] s, input logic [7:0] ptr, input int nb,
                          input logic [15:0] d, input string req);
        bit a;
        bus_start();
        put_byte(adr(s, 1'b0), a); chk(a, {req, " addr ack"}, a, 1);
        put_byte(ptr, a);          chk(a, {req, " ptr ack"}, a, 1);
        if (nb >= 1) begin put_byte(d[15:8], a); chk(a, {req, " hi ack"}, a, 1); end
        if (nb >= 2) begin put_byte(d[7:0], a);  chk(a, {req, " lo ack"}, a, 1); end
        bus_stop();
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [15:0] d, input string req);
        bit a;
        bus_start();
        put_byte(adr(s, 1'b1), a); chk(a, {req, " read addr ack"}, a, 1);
        get_byte(1'b1, d[15:8]);
        get_byte(1'b0, d[7:0]);
        bus_stop();
        exp_rd++;
    endtask

    initial begin
        logic [15:0] d;
        logic [7:0]  b;
        bit a;
        w(10); rst_n = 1'b1; w(10);
        chk(tlow_q == 16'h4B00, "R8 reset low", tlow_q, 16'h4B00);
        chk(thigh_q == 16'h5000, "R8 reset high", thigh_q, 16'h5000);
        chk(cfg_q == 16'h0000, "R8 reset cfg", cfg_q, 0);
        chk(sda_oe == 1'b0, "R1 reset released", sda_oe, 0);
        settled = 1'b1;

        // full word write, then read twice with no new pointer
        settled = 1'b0; wr_reg(strap, 8'h01, 2, 16'hA53C, "R3 cfg write");
        exp_cfg = 16'hA53C; exp_wr[0] += 2; settled = 1'b1;
        settled = 1'b0; rd_reg(strap, d, "R1"); settled = 1'b1;
        chk(d == 16'hA53C, "R4 cfg read", d, 16'hA53C);
        settled = 1'b0; rd_reg(strap, d, "R2"); settled = 1'b1;
        chk(d == 16'hA53C, "R2 pointer persists", d, 16'hA53C);

        // pointer FAh selects the low limit; reserved nibble masked
        settled = 1'b0; wr_reg(strap, 8'hFA, 2, 16'h123F, "R2 low write");
        exp_lo = 16'h1230; exp_wr[1] += 2; settled = 1'b1;
        settled = 1'b0; rd_reg(strap, d, "R8"); settled = 1'b1;
        chk(d == 16'h1230, "R8 reserved bits zero", d, 16'h1230);

        // one data byte then STOP: only the high byte changes
        settled = 1'b0; wr_reg(strap, 8'h03, 1, 16'h6699, "R3 single byte");
        exp_hi = 16'h6600; exp_wr[2] += 1; settled = 1'b1;

        // foreign address: no acknowledge, following bytes ignored
        settled = 1'b0; bus_start();
        put_byte(8'b1001_000_0, a); chk(!a, "R1 foreign addr nack", a, 0);
        put_byte(8'h01, a);         chk(!a, "R1 ignored ptr nack", a, 0);
        put_byte(8'h00, a);         chk(!a, "R1 ignored data nack", a, 0);
        bus_stop(); settled = 1'b1;

        // master code, then repeated START read of the high limit
        settled = 1'b0; bus_start();
        put_byte(8'h0A, a); chk(!a, "R6 master code nack", a, 0);
        rd_reg(strap, d, "R6"); settled = 1'b1;
        chk(d == 16'h6600, "R6 read after master code", d, 16'h6600);

        // strap change takes effect at the next START
        strap = 3'b010;
        settled = 1'b0; bus_start();
        put_byte(adr(3'b101, 1'b0), a); chk(!a, "R1 old strap nack", a, 0);
        bus_stop();
        wr_reg(3'b010, 8'hF9, 2, 16'h0F0F, "R1 new strap");
        exp_cfg = 16'h0F0F; exp_wr[0] += 2; settled = 1'b1;

        // one-shot and temperature pointer writes
        settled = 1'b0; wr_reg(strap, 8'h04, 1, 16'h5500, "R9 oneshot");
        exp_os += 1; settled = 1'b1;
        settled = 1'b0; wr_reg(strap, 8'h00, 2, 16'hFFFF, "R9 temp write"); settled = 1'b1;
        settled = 1'b0; rd_reg(strap, d, "R9"); settled = 1'b1;
        chk(d == 16'h1900, "R9 temp unchanged", d, 16'h1900);
        temp = 12'hC90;
        settled = 1'b0; rd_reg(strap, d, "R4"); settled = 1'b1;
        chk(d == 16'hC900, "R4 negative temp", d, 16'hC900);

        // unused pointer reads zero
        settled = 1'b0; wr_reg(strap, 8'h05, 0, 16'h0, "R4 ptr5");
        rd_reg(strap, d, "R4"); settled = 1'b1;
        chk(d == 16'h0000, "R4 unused ptr zero", d, 0);

        // master NACK after first byte: slave stays silent
        settled = 1'b0; wr_reg(strap, 8'h01, 0, 16'h0, "R5 ptr");
        bus_start();
        put_byte(adr(strap, 1'b1), a); chk(a, "R5 read addr ack", a, 1);
        get_byte(1'b0, b); exp_rd++;
        chk(b == 8'h0F, "R5 first byte", b, 8'h0F);
        for (int k = 0; k < 9; k++) begin
            w(8); scl = 1'b1; w(4);
            chk(sda_line == 1'b1, "R5 released after nack", sda_line, 1);
            w(4); scl = 1'b0;
        end
        bus_stop(); settled = 1'b1;

        // stuck clock during a read: timeout releases SDA
        settled = 1'b0; wr_reg(strap, 8'h02, 0, 16'h0, "R7 ptr");
        bus_start();
        put_byte(adr(strap, 1'b1), a); chk(a, "R7 read addr ack", a, 1);
        exp_rd++;
        w(8);
        chk(sda_line == 1'b0, "R7 driving before timeout", sda_line, 0);
        w(TO + 50);
        chk(sda_line == 1'b1, "R7 released after timeout", sda_line, 1);
        scl = 1'b1; w(20);
        rd_reg(strap, d, "R7"); settled = 1'b1;
        chk(d == 16'h1230, "R7 usable after timeout", d, 16'h1230);

        w(10);
        chk(rd_cnt == exp_rd, "R10 read pulses", rd_cnt, exp_rd);
        chk(os_cnt == exp_os, "R9 oneshot pulses", os_cnt, exp_os);
        for (int k = 0; k < 3; k++)
            chk(wr_cnt[k] == exp_wr[k], "R3 write strobes", wr_cnt[k], exp_wr[k]);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule